// File: doc/BRIEF.md
# Half-Integer Programmable Clock Divider

This block derives an output clock from one of two source clocks, an on-chip oscillator or a clock arriving on an external pin. The output divides the chosen source by an integer from 1 to 16, or by 1.5 or 2.5. Integer ratios, odd ones included, give an exact 50% duty cycle. The two fractional ratios give a narrow pulse of one half source period. They alternate their rising edge between the rising and the falling edge of the source.

The source select and the 5-bit divider code are captured only while reset is asserted. Changes made to them after reset is released have no effect. A small state machine with three states sequences the block. ST_HOLD is entered on reset. It moves to ST_START on the first source rising edge after reset is released, and the first divider cycle begins on that edge. It moves from ST_START to ST_RUN on the rising edge that ends the first full divider repeat, which is when the cycle index equals the last index of the repeat. ST_RUN is left only through reset. A valid flag is high in ST_RUN.

The output is built from two enables, one registered on each source edge. The high half of a source period is passed when the falling-edge enable is set. The low half is passed when the rising-edge enable is set. Each enable changes only while the source is in the phase where it is masked.

Top module: `cfgclk_divider`

## Requirements
- R1: While rst_n is low, clk_out and clk_valid are both 0.
- R2: Divider codes 0 to 15 select integer ratio N = code + 1. For even N the output period is 2N half source periods and the high time is N half periods.
- R3: For an odd integer ratio N, the output period is 2N half source periods and the high time is exactly N half periods, which is a 50% duty cycle.
- R4: Code 0 (ratio 1) passes the source clock: period 2 half periods, high 1 half period.
- R5: Code 16 selects ratio 1.5. Every output period is 3 half source periods with a high time of 1 half period, so rising edges alternate between source rising and falling edges.
- R6: Code 17 selects ratio 2.5. Every output period is 5 half source periods with a high time of 1 half period.
- R7: Codes 18 to 31 fall back to ratio 1.
- R8: src_sel_ext = 1 selects ext_clk as the source; src_sel_ext = 0 selects osc_clk.
- R9: div_code and src_sel_ext are sampled only while rst_n is low. Changing them after release leaves the output period and high time unchanged.
- R10: Let M be the repeat length in source periods: N for integer ratios, 3 for 1.5, 5 for 2.5, and 1 for the fallback. clk_valid is low through the Mth source rising edge after reset release. It goes high at the (M+1)th edge and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Internal oscillator clock |
| ext_clk | input | 1 | External pin clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| src_sel_ext | input | 1 | 1 selects ext_clk, 0 selects osc_clk (sampled in reset) |
| div_code | input | 5 | Ratio code (sampled in reset) |
| clk_out | output | 1 | Divided clock |
| clk_valid | output | 1 | High once the first full repeat has been produced |

## Verification
A wrong cycle index or a wrong repeat length shows up as a wrong output period or high time, measured in half source periods. It is visible within one repeat of the divider, at most 16 source periods. A stuck or mistimed phase enable shows up in the very next output period as a missing high half or an extra high half. A wrong state sequence moves the rising edge of clk_valid away from the (M+1)th source edge. A source-select capture error changes every measured period in nanoseconds from the first period onward.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;
    localparam int CYC_W = 4;
    localparam int NUM_W = 5;

    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_START = 2'd1,
        ST_RUN   = 2'd2
    } div_state_e;

    typedef enum logic {
        MODE_INT  = 1'b0,
        MODE_FRAC = 1'b1
    } ratio_mode_e;

    typedef struct packed {
        ratio_mode_e        mode;
        logic [NUM_W-1:0]   ratio_n;
        logic [CYC_W-1:0]   span;
        logic [CYC_W-1:0]   fall_slot;
    } ratio_cfg_t;
endpackage

// File: rtl/cdiv_ratio_decode.sv
module cdiv_ratio_decode
    import cdiv_pkg::*;
#(
    parameter int CODE_W = 5,
    parameter int MAX_N  = 16
) (
    input  logic [CODE_W-1:0] code,
    output ratio_cfg_t        cfg
);
    localparam logic [CODE_W-1:0] CODE_FRAC_A = CODE_W'(MAX_N);
    localparam logic [CODE_W-1:0] CODE_FRAC_B = CODE_W'(MAX_N + 1);

    always_comb begin
        cfg.mode      = MODE_INT;
        cfg.ratio_n   = NUM_W'(1);
        cfg.span      = '0;
        cfg.fall_slot = '0;
        if (code < CODE_FRAC_A) begin
            cfg.ratio_n = NUM_W'(code) + NUM_W'(1);
            cfg.span    = CYC_W'(code);
        end else if (code == CODE_FRAC_A) begin
            cfg.mode      = MODE_FRAC;
            cfg.span      = CYC_W'(2);
            cfg.fall_slot = CYC_W'(1);
        end else if (code == CODE_FRAC_B) begin
            cfg.mode      = MODE_FRAC;
            cfg.span      = CYC_W'(4);
            cfg.fall_slot = CYC_W'(2);
        end
    end
endmodule

// File: rtl/cdiv_seq_fsm.sv
module cdiv_seq_fsm
    import cdiv_pkg::*;
(
    input  logic             clk_src,
    input  logic             rst_n,
    input  logic [CYC_W-1:0] span,
    output logic [CYC_W-1:0] cyc,
    output logic [CYC_W-1:0] cyc_up,
    output logic             run_valid
);
    div_state_e state_q, state_d;

    always_ff @(posedge clk_src or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
            cyc     <= '0;
        end else begin
            state_q <= state_d;
            cyc     <= cyc_up;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD:  state_d = ST_START;
            ST_START: if (cyc == span) state_d = ST_RUN;
            ST_RUN:   state_d = ST_RUN;
            default:  state_d = ST_HOLD;
        endcase
    end

    always_comb begin
        run_valid = 1'b0;
        cyc_up    = '0;
        unique case (state_q)
            ST_HOLD:  cyc_up = '0;
            ST_START,
            ST_RUN:   cyc_up = (cyc == span) ? '0 : cyc + CYC_W'(1);
            default:  cyc_up = '0;
        endcase
        run_valid = (state_q == ST_RUN);
    end
endmodule

// File: rtl/cdiv_phase_gate.sv
module cdiv_phase_gate
    import cdiv_pkg::*;
(
    input  logic             clk_src,
    input  logic             rst_n,
    input  ratio_cfg_t       cfg,
    input  logic [CYC_W-1:0] cyc_up,
    output logic             en_hi,
    output logic             en_lo
);
    function automatic logic high_slot(input logic [CYC_W-1:0] k, input ratio_cfg_t c);
        if (c.mode == MODE_INT) return ({k, 1'b0} < c.ratio_n);
        else                    return (k == '0);
    endfunction

    function automatic logic low_slot(input logic [CYC_W-1:0] k, input ratio_cfg_t c);
        if (c.mode == MODE_INT) return ({k, 1'b1} < c.ratio_n);
        else                    return (k == c.fall_slot);
    endfunction

    // high-phase enable changes while the source is low
    always_ff @(negedge clk_src or negedge rst_n) begin
        if (!rst_n) en_hi <= 1'b0;
        else        en_hi <= high_slot(cyc_up, cfg);
    end

    // low-phase enable changes while the source is high
    always_ff @(posedge clk_src or negedge rst_n) begin
        if (!rst_n) en_lo <= 1'b0;
        else        en_lo <= low_slot(cyc_up, cfg);
    end
endmodule

// File: rtl/cfgclk_divider.sv
module cfgclk_divider
    import cdiv_pkg::*;
#(
    parameter int CODE_W = 5,
    parameter int MAX_N  = 16
) (
    input  logic              osc_clk,
    input  logic              ext_clk,
    input  logic              rst_n,
    input  logic              src_sel_ext,
    input  logic [CODE_W-1:0] div_code,
    output logic              clk_out,
    output logic              clk_valid
);
    logic              sel_q;
    logic              clk_src;
    logic [CODE_W-1:0] code_q;
    ratio_cfg_t        ratio_cfg;
    logic [CYC_W-1:0]  cyc_now;
    logic [CYC_W-1:0]  cyc_up;
    logic              en_hi;
    logic              en_lo;

    always_ff @(posedge osc_clk) begin
        if (!rst_n) sel_q <= src_sel_ext;
    end

    assign clk_src = sel_q ? ext_clk : osc_clk;

    always_ff @(posedge clk_src) begin
        if (!rst_n) code_q <= div_code;
    end

    cdiv_ratio_decode #(.CODE_W(CODE_W), .MAX_N(MAX_N)) dec_i (
        .code (code_q),
        .cfg  (ratio_cfg)
    );

    cdiv_seq_fsm fsm_i (
        .clk_src   (clk_src),
        .rst_n     (rst_n),
        .span      (ratio_cfg.span),
        .cyc       (cyc_now),
        .cyc_up    (cyc_up),
        .run_valid (clk_valid)
    );

    cdiv_phase_gate gate_i (
        .clk_src (clk_src),
        .rst_n   (rst_n),
        .cfg     (ratio_cfg),
        .cyc_up  (cyc_up),
        .en_hi   (en_hi),
        .en_lo   (en_lo)
    );

    assign clk_out = (clk_src & en_hi) | (~clk_src & en_lo);
endmodule

// File: rtl/cdiv_checker.sv
module cdiv_checker
    import cdiv_pkg::*;
#(
    parameter int CODE_W = 5
) (
    input logic              clk_src,
    input logic              rst_n,
    input logic              clk_out,
    input logic              clk_valid,
    input ratio_cfg_t        ratio_cfg,
    input logic [CYC_W-1:0]  cyc_now,
    input logic              en_hi,
    input logic              en_lo,
    input logic [CODE_W-1:0] code_q
);
    always @(negedge clk_src) begin
        if (!rst_n) begin
            AST_RST_QUIET: assert (!clk_out && !clk_valid); // R1
        end
    end

    AST_VALID_STICKY: assert property (@(posedge clk_src) disable iff (!rst_n)
        clk_valid |=> clk_valid); // R10

    AST_CYC_IN_SPAN: assert property (@(posedge clk_src) disable iff (!rst_n)
        cyc_now <= ratio_cfg.span); // R2

    AST_FRAC_ONE_PHASE: assert property (@(posedge clk_src) disable iff (!rst_n)
        (ratio_cfg.mode == MODE_FRAC) |-> !(en_hi && en_lo)); // R5

    AST_CODE_FROZEN: assert property (@(posedge clk_src) disable iff (!rst_n)
        $stable(code_q)); // R9
endmodule

bind cfgclk_divider cdiv_checker #(.CODE_W(CODE_W)) chk_i (
    .clk_src   (clk_src),
    .rst_n     (rst_n),
    .clk_out   (clk_out),
    .clk_valid (clk_valid),
    .ratio_cfg (ratio_cfg),
    .cyc_now   (cyc_now),
    .en_hi     (en_hi),
    .en_lo     (en_lo),
    .code_q    (code_q)
);

// File: tb/cfgclk_divider_tb_top.sv
`timescale 1ns/100ps
module cfgclk_divider_tb_top;
    logic       osc_clk = 1'b0;
    logic       ext_clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       src_sel_ext = 1'b0;
    logic [4:0] div_code = 5'd0;
    logic       clk_out;
    logic       clk_valid;

    always #5 osc_clk = ~osc_clk;   // 100 MHz, half period 5 ns
    always #4 ext_clk = ~ext_clk;   // 125 MHz, half period 4 ns

    cfgclk_divider dut_i (
        .osc_clk     (osc_clk),
        .ext_clk     (ext_clk),
        .rst_n       (rst_n),
        .src_sel_ext (src_sel_ext),
        .div_code    (div_code),
        .clk_out     (clk_out),
        .clk_valid   (clk_valid)
    );

    typedef struct {
        int    per_ns;
        int    hi_ns;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_tests = 0;
    int   n_fail  = 0;
    bit   meas_on = 1'b0;
    bit   have_prev = 1'b0;
    time  t_rise = 0;
    time  t_fall = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // monitor: measures each output period and pops the scoreboard
    always @(negedge clk_out) t_fall = $time;

    always @(posedge clk_out) begin
        exp_t   e;
        longint per;
        longint hi;
        if (meas_on) begin
            if (have_prev && exp_q.size() > 0) begin
                e   = exp_q.pop_front();
                per = longint'($time - t_rise);
                hi  = longint'(t_fall - t_rise);
                check(per == e.per_ns, e.tag, "period ns", per, e.per_ns);
                check(hi == e.hi_ns, e.tag, "high ns", hi, e.hi_ns);
            end
            t_rise    = $time;
            have_prev = 1'b1;
        end
    end

    task automatic wait_src_pos(input bit sel);
        if (sel) @(posedge ext_clk);
        else     @(posedge osc_clk);
    endtask

    // driver: one configuration, expected items pushed to the scoreboard
    task automatic run_cfg(input bit sel, input logic [4:0] code, input int per_h,
                           input int hi_h, input int m, input string tag, input bit disturb);
        int half;
        half = sel ? 4 : 5;
        meas_on     = 1'b0;
        rst_n       = 1'b0;
        src_sel_ext = sel;
        div_code    = code;
        repeat (4) @(posedge osc_clk);
        repeat (3) wait_src_pos(sel);
        #3;
        check(clk_out == 1'b0 && clk_valid == 1'b0, "R1", "reset outputs",
              {clk_out, clk_valid}, 0);
        wait_src_pos(sel);
        #2;
        rst_n     = 1'b1;
        have_prev = 1'b0;
        meas_on   = 1'b1;
        for (int i = 0; i < 4; i++) exp_q.push_back('{per_h * half, hi_h * half, tag});
        repeat (m) wait_src_pos(sel);
        #1;
        check(clk_valid == 1'b0, "R10", "valid before repeat end", clk_valid, 0);
        wait_src_pos(sel);
        #1;
        check(clk_valid == 1'b1, "R10", "valid after repeat end", clk_valid, 1);
        if (disturb) begin
            div_code    = ~code;
            src_sel_ext = ~sel;
        end
        wait (exp_q.size() == 0);
        meas_on = 1'b0;
        #1;
        check(clk_valid == 1'b1, "R10", "valid held", clk_valid, 1);
    endtask

    initial begin
        string t;
        // R2 even, R3 odd, R4 ratio one
        for (int c = 0; c < 16; c++) begin
            if (c == 0)             t = "R4";
            else if ((c + 1) % 2)   t = "R3";
            else                    t = "R2";
            run_cfg(1'b0, 5'(c), 2 * (c + 1), c + 1, c + 1, t, 1'b0);
        end
        run_cfg(1'b0, 5'd16, 3, 1, 3, "R5", 1'b0);
        run_cfg(1'b0, 5'd17, 5, 1, 5, "R6", 1'b0);
        run_cfg(1'b0, 5'd18, 2, 1, 1, "R7", 1'b0);
        run_cfg(1'b0, 5'd31, 2, 1, 1, "R7", 1'b0);
        run_cfg(1'b1, 5'd2,  6, 3, 3, "R8", 1'b0);
        run_cfg(1'b1, 5'd16, 3, 1, 3, "R8", 1'b0);
        run_cfg(1'b1, 5'd17, 5, 1, 5, "R8", 1'b0);
        run_cfg(1'b0, 5'd5, 12, 6, 6, "R9", 1'b1);
        run_cfg(1'b1, 5'd16, 3, 1, 3, "R9", 1'b1);
        rst_n = 1'b0;
        #20;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule